// File: doc/BRIEF.md
# Comma-Aligned Ten-Bit Character Framer

This block sits behind a bit-rate clock recovery stage. It receives one serial bit per clock and groups the stream into 10-bit transmission characters. The character boundary is not known at the start, so the block watches the incoming stream for the comma pattern that the K28.5 special character carries, in either running-disparity polarity. Each character is delivered in parallel with a one-cycle strobe. The first bit received is placed in the most significant position, so the output reads a, b, c, d, e, i, f, g, h, j from bit 9 down to bit 0.

A comma may move the boundary only while the reframe-enable input is high. With that input low, the block keeps the phase it has. A ready output normally sits high. It drops in the same cycle that a realigned comma character is strobed out, so its falling edge marks the new boundary. It stays low for one character time and then returns high.

Top module: `comma_framer`

## Requirements
- R1: `char_out` carries the ten most recently received bits at each strobe, oldest (bit a) at bit 9 and newest (bit j) at bit 0.
- R2: A comma is bits 9..3 of the candidate window equal to 7'b0011111 or 7'b1100000. With reframe enabled, a comma completing on the current bit strobes that window out as one character on the next cycle.
- R3: While `reframe_en` is low, a comma neither locks the block nor moves the boundary, and the existing character phase is kept.
- R4: Once locked, and with no realignment, `char_strobe` is high for exactly one cycle in every ten.
- R5: After reset, no strobe appears until the first enabled comma.
- R6: On a realignment, `ready` falls in the same cycle as the strobe of the comma character. It stays low for ten cycles and rises with the next strobe.
- R7: A comma that lands on the existing boundary is not a realignment. A repeated K28.5 stream of either polarity (0011111010 or 1100000101) keeps `ready` high and strobes every tenth bit.
- R8: Synchronous active-low reset clears the stored bits and the phase. After reset `char_strobe` is 0, `ready` is 1 and `char_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_bit | input | 1 | Serial data, one bit per clock |
| reframe_en | input | 1 | Permits a comma to set the character boundary |
| char_out | output | 10 | Aligned character, bit 9 = a ... bit 0 = j |
| char_strobe | output | 1 | One-cycle pulse when `char_out` is new |
| ready | output | 1 | Low for one character time after a realignment |

## Verification
Two functions can fall in the same cycle: the free-running counter reaching the end of a character, and the comma detector firing. In an aligned stream of repeated K28.5 they coincide on every character. The bench checks that such a stream gives a single strobe per character and that `ready` stays high. To provoke the other case, three extra bits are slipped into the stream before a comma. The old phase must still strobe its straddling character, and three cycles later the comma must strobe again with `ready` falling. With reframing disabled, the same stimulus must leave the old phase in place.

// File: rtl/cfr_pkg.sv
// Package: shared constants and helpers for the comma framer.
// Assumes a 7-bit comma taken from the first seven bits of a character.
package cfr_pkg;
    localparam int CHAR_BITS  = 10;
    localparam int COMMA_BITS = 7;
    localparam logic [COMMA_BITS-1:0] COMMA_MINUS = 7'b0011111;

    // True when the given 7-bit slice is a comma of either polarity.
    function automatic logic comma_match(input logic [COMMA_BITS-1:0] s);
        return (s == COMMA_MINUS) || (s == ~COMMA_MINUS);
    endfunction
endpackage

// File: rtl/cfr_shifter.sv
// Module: serial input shift register.
// Keeps the last CHAR_W-1 bits and presents the CHAR_W-bit window that
// includes the bit arriving this cycle. The oldest bit is at the top.
// Assumes one valid bit on every clock.
module cfr_shifter #(
    parameter int CHAR_W = cfr_pkg::CHAR_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_bit,
    output logic [CHAR_W-1:0] window_nxt
);
    logic [CHAR_W-2:0] hist_q;

    // Window formed from history plus the incoming bit.
    always_comb window_nxt = {hist_q, rx_bit};

    // Shift the new bit in; reset clears the history.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= window_nxt[CHAR_W-2:0];
    end
endmodule

// File: rtl/cfr_comma_det.sv
// Module: comma detector.
// Compares the first COMMA_W bits of the window against both comma
// polarities. Purely combinational; assumes oldest bit at the MSB.
module cfr_comma_det #(
    parameter int CHAR_W  = cfr_pkg::CHAR_BITS,
    parameter int COMMA_W = cfr_pkg::COMMA_BITS
) (
    input  logic [CHAR_W-1:0] window,
    output logic              comma_hit
);
    localparam logic [COMMA_W-1:0] NEG_PAT = cfr_pkg::COMMA_MINUS;

    logic [COMMA_W-1:0] head;
    logic [1:0]         pol_hit;

    // Leading slice of the candidate character.
    always_comb head = window[CHAR_W-1 -: COMMA_W];

    // One comparator per running-disparity polarity.
    for (genvar p = 0; p < 2; p++) begin : g_pol
        assign pol_hit[p] = (head == ((p == 0) ? NEG_PAT : ~NEG_PAT));
    end

    // Either polarity counts as a comma.
    always_comb comma_hit = |pol_hit;
endmodule

// File: rtl/cfr_align_ctrl.sv
// Module: alignment control.
// Counts bits within a character, emits a character at each boundary,
// and moves the boundary when an enabled comma appears off-phase.
// Assumes window and comma_hit describe the bit arriving this cycle.
module cfr_align_ctrl #(
    parameter int CHAR_W = cfr_pkg::CHAR_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CHAR_W-1:0] window,
    input  logic              comma_hit,
    input  logic              reframe_en,
    output logic [CHAR_W-1:0] char_out,
    output logic              char_strobe,
    output logic              ready
);
    localparam int CNT_W = $clog2(CHAR_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAR_W - 1);

    logic [CNT_W-1:0] bit_cnt;
    logic             locked;
    logic             wrap, realign, emit;

    // Boundary decisions for the bit arriving this cycle.
    always_comb begin
        wrap    = locked && (bit_cnt == LAST);
        realign = reframe_en && comma_hit && !wrap;
        emit    = wrap || realign;
    end

    // Phase counter and lock flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            locked  <= 1'b0;
        end else begin
            bit_cnt <= emit ? '0 : bit_cnt + 1'b1;
            locked  <= locked | realign;
        end
    end

    // Character output, strobe and ready indication.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            char_out    <= '0;
            char_strobe <= 1'b0;
            ready       <= 1'b1;
        end else begin
            char_strobe <= emit;
            if (emit) char_out <= window;
            if (realign)   ready <= 1'b0;
            else if (wrap) ready <= 1'b1;
        end
    end

    // R4
    strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        char_strobe |=> !char_strobe);
    // R5
    unlocked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        char_strobe |-> locked);
    // R6
    ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> char_strobe);
endmodule

// File: rtl/comma_framer.sv
// Module: comma-aligned 10-bit character framer (top).
// Collects a serial stream into characters and aligns on commas while
// reframing is enabled. Assumes one bit per clock and a synchronous reset.
module comma_framer #(
    parameter int CHAR_W  = cfr_pkg::CHAR_BITS,
    parameter int COMMA_W = cfr_pkg::COMMA_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_bit,
    input  logic              reframe_en,
    output logic [CHAR_W-1:0] char_out,
    output logic              char_strobe,
    output logic              ready
);
    logic [CHAR_W-1:0] window_nxt;
    logic              comma_hit;

    cfr_shifter #(.CHAR_W(CHAR_W)) shift_i (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .window_nxt(window_nxt)
    );

    cfr_comma_det #(.CHAR_W(CHAR_W), .COMMA_W(COMMA_W)) det_i (
        .window(window_nxt), .comma_hit(comma_hit)
    );

    cfr_align_ctrl #(.CHAR_W(CHAR_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .window(window_nxt), .comma_hit(comma_hit),
        .reframe_en(reframe_en), .char_out(char_out),
        .char_strobe(char_strobe), .ready(ready)
    );

    // R2
    comma_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> cfr_pkg::comma_match(char_out[CHAR_W-1 -: COMMA_W]));
    // R3
    reframe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> $past(reframe_en));
endmodule

// File: tb/comma_framer_tb.sv
module comma_framer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_bit = 1'b0;
    logic       reframe_en = 1'b0;
    logic [9:0] char_out;
    logic       char_strobe, ready;

    int checks = 0;
    int errors = 0;

    localparam logic [9:0] K_NEG = 10'b0011111010;
    localparam logic [9:0] K_POS = 10'b1100000101;
    localparam logic [9:0] DATA  = 10'b1010101010;

    logic       o_stb, o_rdy;
    logic [9:0] o_chr;

    always #5 clk = ~clk;

    comma_framer dut_i (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .reframe_en(reframe_en),
        .char_out(char_out), .char_strobe(char_strobe), .ready(ready)
    );

    task automatic check(input bit ok, input string req, input logic [9:0] act,
                         input logic [9:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; rx_bit = 1'b0;
        repeat (2) @(posedge clk);
        #1; o_stb = char_strobe; o_rdy = ready; o_chr = char_out;
        @(negedge clk); rst_n = 1'b1;
    endtask

    // Drive one bit and sample the registered outputs after the edge.
    task automatic send_bit(input logic b);
        @(negedge clk); rx_bit = b;
        @(posedge clk); #1;
        o_stb = char_strobe; o_rdy = ready; o_chr = char_out;
    endtask

    // Send a character a-first; a strobe may only appear on its last bit.
    task automatic send_char(input logic [9:0] w, input bit exp_stb,
                             input logic [9:0] exp_chr, input logic exp_rdy,
                             input string req);
        for (int i = 9; i >= 0; i--) begin
            send_bit(w[i]);
            if (i > 0 && o_stb) check(0, req, 10'(o_stb), 10'd0);
        end
        check(o_stb == exp_stb, req, 10'(o_stb), 10'(exp_stb));
        if (exp_stb) begin
            check(o_chr == exp_chr, req, o_chr, exp_chr);
            check(o_rdy == exp_rdy, req, 10'(o_rdy), 10'(exp_rdy));
        end
    endtask

    task automatic t_reset_state();
        do_reset();
        check(o_stb == 1'b0, "R8 strobe", 10'(o_stb), 10'd0);
        check(o_rdy == 1'b1, "R8 ready", 10'(o_rdy), 10'd1);
        check(o_chr == 10'd0, "R8 char", o_chr, 10'd0);
    endtask

    task automatic t_unlocked();
        reframe_en = 1'b1;
        send_char(DATA, 0, 0, 1, "R5 data before comma");
        send_char(DATA, 0, 0, 1, "R5 data before comma");
        reframe_en = 1'b0;
        send_char(K_NEG, 0, 0, 1, "R3 comma ignored while disabled");
        send_char(DATA, 0, 0, 1, "R3 no lock while disabled");
    endtask

    task automatic t_lock();
        reframe_en = 1'b1;
        send_char(K_NEG, 1, K_NEG, 0, "R2 R6 lock on negative comma");
        send_char(DATA, 1, DATA, 1, "R1 R4 R6 next character");
    endtask

    task automatic t_repeat();
        send_char(K_POS, 1, K_POS, 1, "R7 R2 aligned positive comma");
        send_char(K_NEG, 1, K_NEG, 1, "R7 aligned negative comma");
        send_char(K_POS, 1, K_POS, 1, "R7 aligned positive comma");
        send_char(DATA, 1, DATA, 1, "R4 R1 data after commas");
    endtask

    // Slip three bits, then a comma; enabled moves the boundary.
    task automatic t_slip(input bit en);
        reframe_en = en;
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        check(o_stb == 1'b0, "R4 no early strobe", 10'(o_stb), 10'd0);
        for (int i = 9; i >= 3; i--) send_bit(K_NEG[i]);
        check(o_stb == 1'b1, "R4 old phase strobe", 10'(o_stb), 10'd1);
        check(o_chr == 10'b1010011111, "R1 straddling char", o_chr, 10'b1010011111);
        for (int i = 2; i >= 0; i--) send_bit(K_NEG[i]);
        if (en) begin
            check(o_stb == 1'b1, "R2 realign strobe", 10'(o_stb), 10'd1);
            check(o_chr == K_NEG, "R2 realigned char", o_chr, K_NEG);
            check(o_rdy == 1'b0, "R6 ready falls", 10'(o_rdy), 10'd0);
            for (int i = 9; i >= 1; i--) send_bit(DATA[i]);
            check(o_rdy == 1'b0, "R6 ready held low", 10'(o_rdy), 10'd0);
            send_bit(DATA[0]);
            check(o_stb == 1'b1, "R6 strobe after realign", 10'(o_stb), 10'd1);
            check(o_rdy == 1'b1, "R6 ready returns", 10'(o_rdy), 10'd1);
        end else begin
            check(o_stb == 1'b0, "R3 no realign", 10'(o_stb), 10'd0);
            check(o_rdy == 1'b1, "R3 ready kept", 10'(o_rdy), 10'd1);
            for (int i = 9; i >= 3; i--) send_bit(DATA[i]);
            check(o_stb == 1'b1, "R3 phase kept", 10'(o_stb), 10'd1);
            check(o_chr == 10'b0101010101, "R3 phase kept char", o_chr, 10'b0101010101);
        end
    endtask

    task automatic t_reset_mid();
        t_reset_state();
        reframe_en = 1'b1;
        send_char(DATA, 0, 0, 1, "R5 R8 phase cleared by reset");
        send_char(DATA, 0, 0, 1, "R5 R8 phase cleared by reset");
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_unlocked();
        t_lock();
        t_repeat();
        t_slip(1'b1);
        t_repeat();
        t_slip(1'b0);
        t_reset_mid();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule